// File: doc/BRIEF.md
# Tape Track Frame Synchroniser

This block sits behind the clock recovery of a single tape track. Each recovered bit arrives with a one-cycle valid strobe. The block first turns the transition-coded (NRZM) stream into level-coded (NRZL) bits. It then searches those bits for a fixed 36-bit sync word. From the sync word it sets the phase of three counters: one for the bit within a byte, one for the byte within a frame, and one for the address of the track buffer RAM.

Once framed, the block splits the stream into 9-bit bytes: eight data bits followed by one parity bit. For each byte it presents a write strobe, an address and a 9-bit word to the buffer RAM. The word carries the eight data bits and a flag that marks a parity failure.

A processor steers acquisition through a small handshake:
- It arms the search. The next sync word then re-phases every counter and disarms the search.
- After that, each further sync word is graded. A word that ends exactly on the last bit of the frame sets a sticky "confirmed" flag. A word anywhere else sets a sticky "mismatch" flag.

The block also decodes three field windows from the byte counter (header, data and CRC region). It counts parity failures separately for the header and for the data.

Top module: `track_frame_sync`

## Requirements
- R1: The decoded bit is 1 when `nrzm_in` differs from its value at the previous valid bit, and 0 otherwise. The previous value is 0 after reset.
- R2: A sync hit occurs on a valid bit when the last 36 decoded bits equal `SYNC_WORD`. The most recent bit is the LSB and the earliest bit is the MSB.
- R3: A sync hit while `sync_en` is 1 does all of the following: clears `sync_en`, sets `frame_locked`, and loads the address counter from `start_addr`. It also writes no byte for that bit. The next valid bit becomes bit 0 of byte 0.
- R4: `sync_en` is 0 after reset. A one-cycle `arm` pulse sets it, and it takes effect on the following cycle.
- R5: While locked and not armed, a sync hit on bit 8 of byte `frame_len`-1 sets `sync_ok`. The flag stays set until `clr_status`. The counters keep stepping as usual.
- R6: While locked and not armed, a sync hit at any other position sets `sync_nok`, which is sticky. A hit before the first lock, while not armed, changes nothing.
- R7: In each byte the first 8 bits are data, MSB first, and the 9th is parity. Parity is odd over all nine bits. When locked, the cycle after the 9th bit shows the following for exactly one cycle:
  - `wr_en` is 1;
  - `wr_addr` holds the address counter;
  - `wr_data[7:0]` holds the data;
  - `wr_data[8]` is 1 when the nine bits XOR to 0.

  The address counter then steps by 1, wrapping at 2^15.
- R8: The byte counter wraps to 0 after byte `frame_len`-1. The intended range of `frame_len` is 2000 to 4000 bytes, and it may be changed between frames.
- R9: `hdr_win` is 1 for bytes below `hdr_len`. `data_win` is 1 for the remaining bytes. `crc_win` is 1 for bytes from `crc_first` to `crc_last` inclusive. All three are 0 while not locked, and they follow the byte being assembled.
- R10: Each written byte that has a parity failure adds one to `hdr_perr_cnt` if the byte lies below `hdr_len`, and to `data_perr_cnt` otherwise. Both counters saturate.
- R11: `clr_status` clears `sync_ok`, `sync_nok` and both parity counters. A flag being set in the same cycle wins over the clear; a counter being cleared wins over its increment.
- R12: Cycles with `bit_valid` low change no counter, no address and no window, and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A recovered bit is present this cycle |
| nrzm_in | input | 1 | Recovered NRZM track bit |
| arm | input | 1 | Pulse: arm sync acquisition |
| clr_status | input | 1 | Pulse: clear status flags and parity counters |
| frame_len | input | 12 | Frame length in bytes |
| hdr_len | input | 12 | Number of header bytes at the start of the frame |
| crc_first | input | 12 | First byte index of the CRC window |
| crc_last | input | 12 | Last byte index of the CRC window |
| start_addr | input | 15 | Address loaded on armed acquisition |
| sync_en | output | 1 | Acquisition armed |
| sync_ok | output | 1 | Sticky: sync word confirmed at frame end |
| sync_nok | output | 1 | Sticky: sync word seen out of place |
| frame_locked | output | 1 | At least one armed acquisition has happened |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 15 | Byte write address |
| wr_data | output | 9 | {parity-fail flag, 8 data bits} |
| hdr_win | output | 1 | Header field window |
| data_win | output | 1 | Data field window |
| crc_win | output | 1 | CRC region window |
| hdr_perr_cnt | output | 16 | Header parity-failure count |
| data_perr_cnt | output | 16 | Data parity-failure count |

## Verification
The assertions check a set of cycle-level rules on every cycle:
- after an armed hit, the counters re-phase and the address is loaded;
- write strobes are isolated one-cycle pulses;
- idle cycles freeze the counters;
- the status flags stay set until cleared;
- a confirmation is raised only on the last bit of a frame;
- the parity counters never decrease without a clear;
- the header and data windows never overlap.

Several behaviours need whole bit streams, so only the bench scenarios can show them:
- that an unarmed sync word before lock is ignored;
- that a one-bit slip is graded as a mismatch;
- that a changed frame length moves the confirmation point;
- that every byte's data, parity flag and address are correct.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    localparam int SYNC_W = 36;
    localparam int BYTE_BITS = 9;

    typedef struct packed {
        logic       perr;
        logic [7:0] data;
    } tfs_byte_t;
endpackage

// File: rtl/tfs_line_decode.sv
module tfs_line_decode #(
    parameter int                      SYNC_W    = tfs_pkg::SYNC_W,
    parameter logic [SYNC_W-1:0]       SYNC_WORD = 36'h9A5C3E16D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic nrzm_in,
    output logic dec_bit,
    output logic sync_hit
);
    typedef struct packed {
        logic              prev;
        logic [SYNC_W-1:0] win;
    } dec_st_t;

    dec_st_t st_q, st_d;
    logic [SYNC_W-1:0] window;

    always_comb begin
        st_d     = st_q;
        dec_bit  = nrzm_in ^ st_q.prev;
        window   = {st_q.win[SYNC_W-2:0], dec_bit};
        sync_hit = bit_valid && (window == SYNC_WORD);
        if (bit_valid) begin
            st_d.prev = nrzm_in;
            st_d.win  = window;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R12: the decode history only moves on valid bits
    p_dec_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(st_q));
endmodule

// File: rtl/tfs_byte_framer.sv
module tfs_byte_framer #(
    parameter int LEN_W  = 12,
    parameter int ADDR_W = 15,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              dec_bit,
    input  logic              realign,
    input  logic              locked,
    input  logic              clr_status,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [LEN_W-1:0]  crc_first,
    input  logic [LEN_W-1:0]  crc_last,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              at_end,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [8:0]        wr_data,
    output logic              hdr_win,
    output logic              data_win,
    output logic              crc_win,
    output logic [CNT_W-1:0]  hdr_perr_cnt,
    output logic [CNT_W-1:0]  data_perr_cnt
);
    import tfs_pkg::*;

    localparam logic [3:0]       LAST_BIT = 4'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic [3:0]        bit_cnt;
        logic [LEN_W-1:0]  byte_cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        sh;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        tfs_byte_t         wr_word;
        logic [CNT_W-1:0]  hdr_cnt;
        logic [CNT_W-1:0]  dat_cnt;
    } frm_st_t;

    frm_st_t st_q, st_d;
    logic [LEN_W-1:0] last_byte;
    logic             in_hdr;
    logic             perr;

    always_comb begin
        last_byte = frame_len - 1'b1;
        at_end    = (st_q.bit_cnt == LAST_BIT) && (st_q.byte_cnt == last_byte);
        in_hdr    = st_q.byte_cnt < hdr_len;
        perr      = ~^{st_q.sh, dec_bit};
        hdr_win   = locked && in_hdr;
        data_win  = locked && !in_hdr;
        crc_win   = locked && (st_q.byte_cnt >= crc_first) && (st_q.byte_cnt <= crc_last);

        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (clr_status) begin
            st_d.hdr_cnt = '0;
            st_d.dat_cnt = '0;
        end
        if (bit_valid) begin
            st_d.sh = {st_q.sh[6:0], dec_bit};
            if (realign) begin
                st_d.bit_cnt  = '0;
                st_d.byte_cnt = '0;
                st_d.addr     = start_addr;
            end else if (st_q.bit_cnt == LAST_BIT) begin
                st_d.bit_cnt  = '0;
                st_d.byte_cnt = (st_q.byte_cnt >= last_byte) ? '0 : st_q.byte_cnt + 1'b1;
                if (locked) begin
                    st_d.wr_en        = 1'b1;
                    st_d.wr_addr      = st_q.addr;
                    st_d.wr_word.perr = perr;
                    st_d.wr_word.data = st_q.sh;
                    st_d.addr         = st_q.addr + 1'b1;
                    if (perr && !clr_status) begin
                        if (in_hdr) begin
                            if (st_q.hdr_cnt != CNT_MAX) st_d.hdr_cnt = st_q.hdr_cnt + 1'b1;
                        end else begin
                            if (st_q.dat_cnt != CNT_MAX) st_d.dat_cnt = st_q.dat_cnt + 1'b1;
                        end
                    end
                end
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en         = st_q.wr_en;
    assign wr_addr       = st_q.wr_addr;
    assign wr_data       = st_q.wr_word;
    assign hdr_perr_cnt  = st_q.hdr_cnt;
    assign data_perr_cnt = st_q.dat_cnt;

    p_realign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && realign) |=> (st_q.bit_cnt == 0) && (st_q.byte_cnt == 0)
            && (st_q.addr == $past(start_addr)) && !wr_en);

    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.addr == wr_addr + 1'b1));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(st_q.bit_cnt) && $stable(st_q.byte_cnt)
            && $stable(st_q.addr) && !wr_en);

    p_cnt_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_status |=> (hdr_perr_cnt >= $past(hdr_perr_cnt))
            && (data_perr_cnt >= $past(data_perr_cnt)));

    p_win_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_win && data_win));
endmodule

// File: rtl/tfs_sync_ctrl.sv
module tfs_sync_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_hit,
    input  logic at_end,
    input  logic arm,
    input  logic clr_status,
    output logic realign,
    output logic locked,
    output logic sync_en,
    output logic sync_ok,
    output logic sync_nok
);
    typedef struct packed {
        logic armed;
        logic locked;
        logic ok;
        logic nok;
    } ctl_st_t;

    ctl_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        realign = sync_hit && st_q.armed;
        if (clr_status) begin
            st_d.ok  = 1'b0;
            st_d.nok = 1'b0;
        end
        if (sync_hit) begin
            if (st_q.armed) begin
                st_d.armed  = 1'b0;
                st_d.locked = 1'b1;
            end else if (st_q.locked) begin
                if (at_end) st_d.ok  = 1'b1;
                else        st_d.nok = 1'b1;
            end
        end
        if (arm) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked   = st_q.locked;
    assign sync_en  = st_q.armed;
    assign sync_ok  = st_q.ok;
    assign sync_nok = st_q.nok;

    p_arm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> sync_en);

    p_ok_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_ok && !clr_status) |=> sync_ok);

    p_ok_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> $past(at_end) && $past(sync_hit));

    p_nok_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_nok && !clr_status) |=> sync_nok);
endmodule

// File: rtl/track_frame_sync.sv
module track_frame_sync #(
    parameter int                          LEN_W     = 12,
    parameter int                          ADDR_W    = 15,
    parameter int                          CNT_W     = 16,
    parameter logic [tfs_pkg::SYNC_W-1:0]  SYNC_WORD = 36'h9A5C3E16D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              nrzm_in,
    input  logic              arm,
    input  logic              clr_status,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [LEN_W-1:0]  crc_first,
    input  logic [LEN_W-1:0]  crc_last,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              sync_en,
    output logic              sync_ok,
    output logic              sync_nok,
    output logic              frame_locked,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [8:0]        wr_data,
    output logic              hdr_win,
    output logic              data_win,
    output logic              crc_win,
    output logic [CNT_W-1:0]  hdr_perr_cnt,
    output logic [CNT_W-1:0]  data_perr_cnt
);
    logic dec_bit, sync_hit, realign, at_end;

    tfs_line_decode #(.SYNC_W(tfs_pkg::SYNC_W), .SYNC_WORD(SYNC_WORD)) u_decode (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .nrzm_in(nrzm_in),
        .dec_bit(dec_bit), .sync_hit(sync_hit)
    );

    tfs_sync_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sync_hit(sync_hit), .at_end(at_end),
        .arm(arm), .clr_status(clr_status), .realign(realign),
        .locked(frame_locked), .sync_en(sync_en), .sync_ok(sync_ok),
        .sync_nok(sync_nok)
    );

    tfs_byte_framer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .dec_bit(dec_bit),
        .realign(realign), .locked(frame_locked), .clr_status(clr_status),
        .frame_len(frame_len), .hdr_len(hdr_len), .crc_first(crc_first),
        .crc_last(crc_last), .start_addr(start_addr), .at_end(at_end),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hdr_win(hdr_win), .data_win(data_win), .crc_win(crc_win),
        .hdr_perr_cnt(hdr_perr_cnt), .data_perr_cnt(data_perr_cnt)
    );
endmodule

// File: tb/track_frame_sync_bench.sv
module track_frame_sync_bench;
    localparam logic [35:0] SYNC = 36'h9A5C3E16D;
    localparam int HDR = 12, CRC_A = 8, CRC_B = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_valid = 1'b0, nrzm_in = 1'b0, arm = 1'b0, clr_status = 1'b0;
    logic [11:0] frame_len = 12'd2000;
    logic [11:0] hdr_len = 12'(HDR), crc_first = 12'(CRC_A), crc_last = 12'(CRC_B);
    logic [14:0] start_addr = 15'h7F00;
    logic sync_en, sync_ok, sync_nok, frame_locked, wr_en, hdr_win, data_win, crc_win;
    logic [14:0] wr_addr;
    logic [8:0]  wr_data;
    logic [15:0] hdr_perr_cnt, data_perr_cnt;

    always #5 clk = ~clk;

    track_frame_sync u_track_frame_sync (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .nrzm_in(nrzm_in),
        .arm(arm), .clr_status(clr_status), .frame_len(frame_len),
        .hdr_len(hdr_len), .crc_first(crc_first), .crc_last(crc_last),
        .start_addr(start_addr), .sync_en(sync_en), .sync_ok(sync_ok),
        .sync_nok(sync_nok), .frame_locked(frame_locked), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .hdr_win(hdr_win),
        .data_win(data_win), .crc_win(crc_win), .hdr_perr_cnt(hdr_perr_cnt),
        .data_perr_cnt(data_perr_cnt)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic        m_prev = 0, m_armed = 0, m_locked = 0, m_ok = 0, m_nok = 0;
    logic [35:0] m_win = '0;
    logic [7:0]  m_sh = '0;
    logic [14:0] m_addr = '0;
    int          m_bitc = 0, m_bytec = 0, m_hc = 0, m_dc = 0;
    logic        exp_wr = 0;
    logic [14:0] exp_addr = '0;
    logic [8:0]  exp_data = '0;
    logic        enc_st = 0;

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v == 65535) ? v : v + 1;
    endfunction

    task automatic do_cycle(input logic v, input logic enc, input logic a, input logic c);
        logic d;
        logic [8:0] nine;
        logic hit, at_end, bad;
        @(negedge clk);
        bit_valid = v; nrzm_in = enc; arm = a; clr_status = c;
        exp_wr = 1'b0;
        if (c) begin m_ok = 0; m_nok = 0; m_hc = 0; m_dc = 0; end
        if (v) begin
            d      = enc ^ m_prev;                       // R1
            m_prev = enc;
            m_win  = {m_win[34:0], d};
            hit    = (m_win == SYNC);                    // R2
            at_end = (m_bitc == 8) && (m_bytec == int'(frame_len) - 1);
            nine   = {m_sh, d};
            bad    = ~^nine;
            if (hit && m_armed) begin                    // R3
                m_armed = 0; m_locked = 1; m_bitc = 0; m_bytec = 0; m_addr = start_addr;
            end else begin
                if (hit && m_locked) begin
                    if (at_end) m_ok = 1; else m_nok = 1;
                end
                if (m_bitc == 8) begin
                    if (m_locked) begin
                        exp_wr = 1; exp_addr = m_addr; exp_data = {bad, m_sh};
                        m_addr = m_addr + 1'b1;
                        if (bad && !c) begin
                            if (m_bytec < int'(hdr_len)) m_hc = sat_inc(m_hc);
                            else m_dc = sat_inc(m_dc);
                        end
                    end
                    m_bitc = 0;
                    m_bytec = (m_bytec >= int'(frame_len) - 1) ? 0 : m_bytec + 1;
                end else m_bitc++;
            end
            m_sh = {m_sh[6:0], d};
        end
        if (a) m_armed = 1;
        @(posedge clk); #1;
        chk(wr_en == exp_wr, v ? "R7 wr_en" : "R12 wr_en idle", wr_en, exp_wr);
        if (exp_wr) begin
            chk(wr_addr == exp_addr, "R7 wr_addr", wr_addr, exp_addr);
            chk(wr_data == exp_data, "R1 R7 wr_data", wr_data, exp_data);
        end
        chk(sync_en == m_armed, "R4 sync_en", sync_en, m_armed);
        chk(frame_locked == m_locked, "R3 frame_locked", frame_locked, m_locked);
        chk(sync_ok == m_ok, "R5 sync_ok", sync_ok, m_ok);
        chk(sync_nok == m_nok, "R6 sync_nok", sync_nok, m_nok);
        chk(hdr_perr_cnt == 16'(m_hc), "R10 hdr_perr_cnt", hdr_perr_cnt, m_hc);
        chk(data_perr_cnt == 16'(m_dc), "R10 data_perr_cnt", data_perr_cnt, m_dc);
        chk(hdr_win == (m_locked && m_bytec < HDR), "R9 hdr_win", hdr_win, m_locked && m_bytec < HDR);
        chk(data_win == (m_locked && m_bytec >= HDR), "R9 data_win", data_win, m_locked && m_bytec >= HDR);
        chk(crc_win == (m_locked && m_bytec >= CRC_A && m_bytec <= CRC_B), "R9 crc_win",
            crc_win, m_locked && m_bytec >= CRC_A && m_bytec <= CRC_B);
        arm = 0; clr_status = 0;
    endtask

    task automatic send_bit(input logic d);
        if ($urandom % 8 == 0) do_cycle(1'b0, 1'($urandom), 1'b0, 1'b0);   // R12 gap
        enc_st = enc_st ^ d;
        do_cycle(1'b1, enc_st, 1'b0, 1'b0);
    endtask

    task automatic send_byte(input logic [7:0] data, input bit corrupt);
        logic par;
        par = ~(^data);
        if (corrupt) par = ~par;
        for (int i = 7; i >= 0; i--) send_bit(data[i]);
        send_bit(par);
    endtask

    task automatic send_sync();
        for (int i = 35; i >= 0; i--) send_bit(SYNC[i]);
    endtask

    task automatic send_body(input int nbytes);
        for (int k = 0; k < nbytes; k++)
            send_byte(8'($urandom), (k == 3) || (k == HDR + 5) || ($urandom % 16 == 0));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0141);
        repeat (3) @(posedge clk);
        #1;
        chk(sync_en == 0 && sync_ok == 0 && sync_nok == 0 && wr_en == 0,
            "R4 reset flags", {sync_en, sync_ok, sync_nok, wr_en}, 0);
        @(negedge clk); rst_n = 1'b1;

        // unarmed sync before lock is ignored (R6)
        for (int i = 0; i < 60; i++) send_bit(1'($urandom));
        send_sync();
        chk(frame_locked == 0 && sync_nok == 0, "R6 unlocked hit ignored",
            {frame_locked, sync_nok}, 0);

        // arm and acquire (R2 R3 R4)
        do_cycle(1'b0, 1'b0, 1'b1, 1'b0);
        chk(sync_en == 1, "R4 arm", sync_en, 1);
        for (int i = 0; i < 23; i++) send_bit(1'($urandom));
        send_sync();
        chk(sync_en == 0 && frame_locked == 1, "R2 R3 acquire", {sync_en, frame_locked}, 2'b01);

        // sync exactly one frame later (R5)
        send_body(2000 - 4);
        send_sync();
        chk(sync_ok == 1 && sync_nok == 0, "R5 confirm", {sync_ok, sync_nok}, 2'b10);
        chk(hdr_perr_cnt >= 1 && data_perr_cnt >= 1, "R10 both counted",
            {hdr_perr_cnt, data_perr_cnt}, 1);

        // clear (R11)
        do_cycle(1'b0, 1'b0, 1'b0, 1'b1);
        chk(sync_ok == 0 && hdr_perr_cnt == 0 && data_perr_cnt == 0, "R11 clear",
            {sync_ok, hdr_perr_cnt, data_perr_cnt}, 0);

        // one-bit slip gives a mismatch (R6)
        send_body(2000 - 4);
        send_bit(1'b0);
        send_sync();
        chk(sync_nok == 1 && sync_ok == 0, "R6 slip", {sync_nok, sync_ok}, 2'b10);

        // re-arm, new start address and a longer frame (R3 R8)
        do_cycle(1'b0, 1'b0, 1'b0, 1'b1);
        start_addr = 15'h0123;
        frame_len  = 12'd2001;
        do_cycle(1'b0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 17; i++) send_bit(1'($urandom));
        send_sync();
        send_body(2001 - 4);
        send_sync();
        chk(sync_ok == 1 && sync_nok == 0, "R8 longer frame confirm", {sync_ok, sync_nok}, 2'b10);
        for (int i = 0; i < 40; i++) do_cycle(1'b0, 1'($urandom), 1'b0, 1'b0);
        finish_run();
    end
endmodule